// File: doc/BRIEF.md
# Overlap-Safe Three-Region Memory Protection Unit

This unit decides whether a software memory request may proceed. It watches a 16-bit address space with three programmable protection regions. Each region has a range register, which holds a base and a size, and a policy register of six permission bits. Every request carries an address, an access kind and the requester's privilege level. The unit answers with one combinational grant bit. Each region filter passes any address it does not cover. The request is granted only when every filter passes. Overlapping regions therefore combine by intersection of their permissions, so a loosely configured region can never widen what a stricter region allows.

Region configuration arrives through a single-cycle write port that carries the writer's privilege. Regions 0 and 1 belong to privileged software. Region 2 may be programmed by unprivileged software, but it can never be placed on top of region 0 or region 1. The two states of the configuration controller are named here:
- `CFG_CLEAN`: no write has been refused since reset.
- `CFG_FAULTED`: at least one write has been refused.

The controller has one transition, `CLEAN->FAULTED`, taken when a write is refused. It has no transition out of `CFG_FAULTED` except reset. The error output shows which of the two states the controller is in.

Top module: `mpu_guard`

## Requirements
- R1: After reset all range and policy registers are zero, every region is disabled, every read, write and execute request at either privilege is granted, and `cfg_err` is 0.
- R2: In a range write, `cfg_wdata[15:0]` is the base and `cfg_wdata[31:16]` is the size. A region covers an address `a` when base <= a < base+size, where the sum is taken without wrap-around. A size of zero disables the region.
- R3: Policy bits are: bit 0 read, unprivileged; bit 1 write, unprivileged; bit 2 execute, unprivileged; bit 3 read, privileged; bit 4 write, privileged; bit 5 execute, privileged. Bits 31:6 of a policy write have no effect.
- R4: `req_kind` is encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. A reserved request is never granted, at any address.
- R5: A request is granted only if every region covering its address permits that kind of access at that privilege. A region that does not cover the address does not restrict it.
- R6: A privileged write (`cfg_priv`=1) to any region register takes effect on the next clock. `cfg_field` selects the register: 0 = range, 1 = policy.
- R7: An unprivileged write to a register of region 0 or region 1 leaves that register unchanged and sets `cfg_err`.
- R8: Unprivileged policy writes to region 2 are accepted. Unprivileged range writes to region 2 are also accepted when the new range does not overlap an enabled region 0 or region 1. A range that only touches a neighbour's end is not an overlap.
- R9: An unprivileged range write to region 2 that overlaps an enabled region 0 or region 1 is dropped, so the old range stays in force, and it sets `cfg_err`.
- R10: `cfg_err` stays set until reset, through later accepted writes and idle cycles.
- R11: A write with `cfg_sel` = 3 changes nothing and does not set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_sel | input | 2 | Region index (3 = none) |
| cfg_field | input | 1 | 0 = range register, 1 = policy register |
| cfg_wdata | input | 32 | Write data |
| req_addr | input | 16 | Request address |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| req_priv | input | 1 | Requester is privileged |
| grant | output | 1 | Request permitted (combinational) |
| cfg_err | output | 1 | Sticky refused-write flag |

## Verification
Probes at the first and last covered address, at the address just past the end, and at the address just below the base distinguish a correct exclusive end from an off-by-one. A region placed at the top of memory shows whether the end sum wraps around. Two privileged regions that overlap, with different policies, separate intersection of permissions from a first-match rule. Three unprivileged region 2 placements tell apart a real overlap check, a check that also refuses ranges that merely touch, and no check at all: one is disjoint, one touches region 0's end, one overlaps region 0. A random mix of writes from both privileges, including the unused region index, is then compared every cycle against a behavioural model.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        CFG_CLEAN   = 1'b0,
        CFG_FAULTED = 1'b1
    } cfg_state_e;

    typedef enum logic {
        FLD_RANGE  = 1'b0,
        FLD_POLICY = 1'b1
    } cfg_field_e;

    localparam int POL_W     = 6;
    localparam int POL_RD_NP = 0;
    localparam int POL_WR_NP = 1;
    localparam int POL_EX_NP = 2;
    localparam int POL_RD_P  = 3;
    localparam int POL_WR_P  = 4;
    localparam int POL_EX_P  = 5;

endpackage

// File: rtl/mpu_region_filter.sv
module mpu_region_filter
    import mpu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_kind_e         kind,
    input  logic              priv,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  logic [POL_W-1:0]  pol,
    output logic              pass
);
    logic [ADDR_W:0] limit;
    logic            hit;
    logic            allow;

    always_comb begin
        limit = {1'b0, base} + {1'b0, size};
        hit   = (size != '0) && (addr >= base) && ({1'b0, addr} < limit);
    end

    always_comb begin
        unique case (kind)
            ACC_READ:  allow = priv ? pol[POL_RD_P] : pol[POL_RD_NP];
            ACC_WRITE: allow = priv ? pol[POL_WR_P] : pol[POL_WR_NP];
            ACC_EXEC:  allow = priv ? pol[POL_EX_P] : pol[POL_EX_NP];
            ACC_RSVD:  allow = 1'b0;
        endcase
        pass = !hit || allow;
    end
endmodule

// File: rtl/mpu_overlap_check.sv
module mpu_overlap_check #(
    parameter int ADDR_W      = 16,
    parameter int NUM_REGIONS = 3,
    parameter int NUM_PRIV    = 2
) (
    input  logic [ADDR_W-1:0]                  new_base,
    input  logic [ADDR_W-1:0]                  new_size,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] cur_base,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] cur_size,
    output logic                               clash
);
    logic [ADDR_W:0]     new_limit;
    logic [NUM_PRIV-1:0] hit;

    assign new_limit = {1'b0, new_base} + {1'b0, new_size};

    for (genvar g = 0; g < NUM_PRIV; g++) begin : g_prot
        logic [ADDR_W:0] cur_limit;
        assign cur_limit = {1'b0, cur_base[g]} + {1'b0, cur_size[g]};
        assign hit[g] = (new_size != '0) && (cur_size[g] != '0)
                     && ({1'b0, new_base} < cur_limit)
                     && ({1'b0, cur_base[g]} < new_limit);
    end

    assign clash = |hit;
endmodule

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NUM_REGIONS = 3,
    parameter int NUM_PRIV    = 2,
    parameter int CFG_W       = 32,
    parameter int SEL_W       = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic                               priv,
    input  logic [SEL_W-1:0]                   sel,
    input  cfg_field_e                         field,
    input  logic [CFG_W-1:0]                   wdata,
    input  logic                               clash,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0] size_q,
    output logic [NUM_REGIONS-1:0][POL_W-1:0]  pol_q,
    output logic                               err
);
    cfg_state_e state_q, state_d;
    logic       sel_valid;
    logic       sel_prot;
    logic       refuse;
    logic       accept;

    always_comb begin
        sel_valid = int'(sel) < NUM_REGIONS;
        sel_prot  = int'(sel) < NUM_PRIV;
        refuse    = we && sel_valid && !priv
                 && (sel_prot || (field == FLD_RANGE && clash));
        accept    = we && sel_valid && !refuse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_CLEAN:   if (refuse) state_d = CFG_FAULTED;
            CFG_FAULTED: state_d = CFG_FAULTED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CFG_CLEAN:   err = 1'b0;
            CFG_FAULTED: err = 1'b1;
        endcase
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
        logic hit_me;
        assign hit_me = accept && (int'(sel) == r);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[r] <= '0;
                size_q[r] <= '0;
                pol_q[r]  <= '0;
            end else if (hit_me) begin
                if (field == FLD_RANGE) begin
                    base_q[r] <= wdata[ADDR_W-1:0];
                    size_q[r] <= wdata[2*ADDR_W-1:ADDR_W];
                end else begin
                    pol_q[r]  <= wdata[POL_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
    import mpu_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NUM_REGIONS = 3,
    parameter int NUM_PRIV    = 2,
    parameter int CFG_W       = 32,
    parameter int SEL_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_priv,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_field,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    output logic              grant,
    output logic              cfg_err
);
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] reg_base;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] reg_size;
    logic [NUM_REGIONS-1:0][POL_W-1:0]  reg_pol;
    logic [NUM_REGIONS-1:0]             pass;
    logic                               clash;
    acc_kind_e                          kind;

    assign kind = acc_kind_e'(req_kind);

    mpu_overlap_check #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .NUM_PRIV(NUM_PRIV)
    ) u_overlap (
        .new_base (cfg_wdata[ADDR_W-1:0]),
        .new_size (cfg_wdata[2*ADDR_W-1:ADDR_W]),
        .cur_base (reg_base),
        .cur_size (reg_size),
        .clash    (clash)
    );

    mpu_cfg_regs #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .NUM_PRIV(NUM_PRIV),
        .CFG_W(CFG_W), .SEL_W(SEL_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .priv   (cfg_priv),
        .sel    (cfg_sel),
        .field  (cfg_field_e'(cfg_field)),
        .wdata  (cfg_wdata),
        .clash  (clash),
        .base_q (reg_base),
        .size_q (reg_size),
        .pol_q  (reg_pol),
        .err    (cfg_err)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_flt
        mpu_region_filter #(.ADDR_W(ADDR_W)) u_flt (
            .addr (req_addr),
            .kind (kind),
            .priv (req_priv),
            .base (reg_base[r]),
            .size (reg_size[r]),
            .pol  (reg_pol[r]),
            .pass (pass[r])
        );
    end

    assign grant = (&pass) && (kind != ACC_RSVD);
endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk #(
    parameter int ADDR_W      = 16,
    parameter int NUM_REGIONS = 3,
    parameter int NUM_PRIV    = 2,
    parameter int CFG_W       = 32,
    parameter int SEL_W       = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               cfg_we,
    input logic                               cfg_priv,
    input logic [SEL_W-1:0]                   cfg_sel,
    input logic                               cfg_field,
    input logic [CFG_W-1:0]                   cfg_wdata,
    input logic [ADDR_W-1:0]                  req_addr,
    input logic [1:0]                         req_kind,
    input logic                               req_priv,
    input logic                               grant,
    input logic                               cfg_err,
    input logic                               clash,
    input logic [NUM_REGIONS-1:0][ADDR_W-1:0] reg_base,
    input logic [NUM_REGIONS-1:0][ADDR_W-1:0] reg_size,
    input logic [NUM_REGIONS-1:0][5:0]        reg_pol
);
    localparam int LAST = NUM_REGIONS - 1;

    a_r7_prot_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv && int'(cfg_sel) < NUM_PRIV)
        |=> (cfg_err && $stable(reg_base[NUM_PRIV-1:0])
             && $stable(reg_size[NUM_PRIV-1:0]) && $stable(reg_pol[NUM_PRIV-1:0])));

    a_r9_clash_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv && int'(cfg_sel) == LAST && !cfg_field && clash)
        |=> (cfg_err && $stable(reg_base[LAST]) && $stable(reg_size[LAST])));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r4_rsvd_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == 2'd3) |-> !grant);

    a_r6_priv_policy: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_priv && cfg_sel == '0 && cfg_field)
        |=> (reg_pol[0] == $past(cfg_wdata[5:0])));

    a_r5_region0_read: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_kind == 2'd0 && !req_priv && reg_size[0] != '0
         && req_addr >= reg_base[0]
         && {1'b0, req_addr} < ({1'b0, reg_base[0]} + {1'b0, reg_size[0]}))
        |-> reg_pol[0][0]);
endmodule

bind mpu_guard mpu_guard_chk #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .NUM_PRIV(NUM_PRIV),
    .CFG_W(CFG_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
    .grant(grant), .cfg_err(cfg_err), .clash(clash),
    .reg_base(reg_base), .reg_size(reg_size), .reg_pol(reg_pol)
);

// File: tb/test_mpu_guard.sv
module test_mpu_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_priv = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic        cfg_field = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        grant;
    logic        cfg_err;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int m_base[3];
    int m_size[3];
    int m_pol[3];
    int m_err;

    always #5 clk = ~clk;

    mpu_guard i_mpu_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
        .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
        .grant(grant), .cfg_err(cfg_err)
    );

    function automatic int ref_grant(int a, int k, int p);
        if (k == 3) return 0;
        for (int r = 0; r < 3; r++) begin
            if (m_size[r] != 0 && a >= m_base[r] && a < m_base[r] + m_size[r])
                if (((m_pol[r] >> (p * 3 + k)) & 1) == 0) return 0;
        end
        return 1;
    endfunction

    function automatic void ref_write(int sel, int pv, int fld, logic [31:0] d);
        int nb = int'(d[15:0]);
        int ns = int'(d[31:16]);
        bit hit = 0;
        if (sel > 2) return;
        if (sel < 2 && pv == 0) begin m_err = 1; return; end
        if (sel == 2 && pv == 0 && fld == 0) begin
            for (int r = 0; r < 2; r++)
                if (ns != 0 && m_size[r] != 0 && nb < m_base[r] + m_size[r] && m_base[r] < nb + ns)
                    hit = 1;
            if (hit) begin m_err = 1; return; end
        end
        if (fld == 0) begin m_base[sel] = nb; m_size[sel] = ns; end
        else m_pol[sel] = int'(d[5:0]);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(grant) == ref_grant(int'(req_addr), int'(req_kind), int'(req_priv)),
                "R5 model grant", int'(grant),
                ref_grant(int'(req_addr), int'(req_kind), int'(req_priv)));
            chk(int'(cfg_err) == m_err, "R10 model err", int'(cfg_err), m_err);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        for (int r = 0; r < 3; r++) begin m_base[r] = 0; m_size[r] = 0; m_pol[r] = 0; end
        m_err = 0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic cfg_write(int sel, int pv, int fld, logic [31:0] d);
        cfg_sel = sel[1:0]; cfg_priv = pv[0]; cfg_field = fld[0]; cfg_wdata = d;
        cfg_we = 1'b1;
        @(posedge clk);
        ref_write(sel, pv, fld, d);
        #1 cfg_we = 1'b0;
    endtask

    task automatic probe(int a, int k, int p, int exp, string tag);
        req_addr = a[15:0]; req_kind = k[1:0]; req_priv = p[0];
        #1;
        chk(int'(grant) == exp, tag, int'(grant), exp);
        @(posedge clk); #1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state open
        probe(16'h0000, 0, 0, 1, "R1 read np");
        probe(16'hFFFF, 2, 1, 1, "R1 exec p");
        probe(16'h8000, 1, 0, 1, "R1 write np");
        chk(cfg_err == 1'b0, "R1 err", int'(cfg_err), 0);
        // R4
        probe(16'h1234, 3, 1, 0, "R4 reserved");
        // R6 R2 R3
        cfg_write(0, 1, 0, {16'h0100, 16'h1000});
        cfg_write(0, 1, 1, 32'h18);
        probe(16'h1000, 0, 0, 0, "R2 base np read");
        probe(16'h1000, 0, 1, 1, "R6 priv read");
        probe(16'h1000, 2, 1, 0, "R3 exec_p clear");
        probe(16'h10FF, 1, 0, 0, "R2 last addr");
        probe(16'h1100, 0, 0, 1, "R2 end exclusive");
        probe(16'h0FFF, 0, 0, 1, "R2 below base");
        cfg_write(1, 1, 0, {16'h0010, 16'h2000});
        cfg_write(1, 1, 1, 32'hFFFF_FFC1);
        probe(16'h2000, 0, 0, 1, "R3 read_np");
        probe(16'h2000, 1, 0, 0, "R3 write_np");
        probe(16'h2000, 0, 1, 0, "R3 upper bits ignored");
        // R11
        cfg_write(3, 0, 0, 32'h0010_1000);
        chk(cfg_err == 1'b0, "R11 no err", int'(cfg_err), 0);
        probe(16'h1000, 0, 1, 1, "R11 unchanged");
        // R8
        cfg_write(2, 0, 0, {16'h0010, 16'h3000});
        cfg_write(2, 0, 1, 32'h0);
        chk(cfg_err == 1'b0, "R8 no err", int'(cfg_err), 0);
        probe(16'h3000, 0, 1, 0, "R8 region2 active");
        probe(16'h3010, 0, 0, 1, "R8 region2 end");
        cfg_write(2, 0, 0, {16'h0010, 16'h1100});
        probe(16'h1100, 0, 0, 0, "R8 touching accepted");
        probe(16'h3000, 0, 0, 1, "R8 old range gone");
        chk(cfg_err == 1'b0, "R8 touch no err", int'(cfg_err), 0);
        // R9
        cfg_write(2, 0, 0, {16'h0200, 16'h0F00});
        chk(cfg_err == 1'b1, "R9 err", int'(cfg_err), 1);
        probe(16'h0F80, 0, 0, 1, "R9 dropped");
        probe(16'h1100, 0, 0, 0, "R9 old kept");
        // R10
        cfg_write(2, 1, 0, {16'h0010, 16'h4000});
        probe(16'h4000, 0, 0, 0, "R6 priv region2");
        repeat (3) @(posedge clk);
        #1 chk(cfg_err == 1'b1, "R10 sticky", int'(cfg_err), 1);
        // reset again
        do_reset();
        chk(cfg_err == 1'b0, "R1 err after reset", int'(cfg_err), 0);
        probe(16'h1000, 0, 0, 1, "R1 cleared");
        // R7
        cfg_write(0, 1, 0, {16'h0100, 16'h1000});
        cfg_write(0, 1, 1, 32'h18);
        cfg_write(0, 0, 0, {16'h0100, 16'h5000});
        cfg_write(0, 0, 1, 32'h3F);
        chk(cfg_err == 1'b1, "R7 err", int'(cfg_err), 1);
        probe(16'h1000, 0, 0, 0, "R7 ignored");
        probe(16'h5000, 0, 0, 1, "R7 not moved");
        // R2 no wrap
        cfg_write(1, 1, 0, {16'h0020, 16'hFFF0});
        cfg_write(1, 1, 1, 32'h0);
        probe(16'hFFF8, 0, 1, 0, "R2 top region");
        probe(16'h0005, 0, 1, 1, "R2 no wrap");
        // R5 overlap of two regions
        cfg_write(1, 1, 0, {16'h0040, 16'h1080});
        cfg_write(1, 1, 1, 32'h08);
        probe(16'h1090, 1, 1, 0, "R5 intersect write");
        probe(16'h1090, 0, 1, 1, "R5 intersect read");
        probe(16'h1010, 1, 1, 1, "R5 single region");
        // random mix, compared each cycle
        do_reset();
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [31:0] d;
                d = $urandom;
                if ($urandom_range(0, 1) == 0)
                    d = {4'h0, 4'($urandom_range(0, 3)), 8'h00,
                         4'($urandom_range(0, 7)), 4'($urandom_range(0, 3)), 8'h00};
                cfg_write(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                          int'($urandom_range(0, 1)), d);
            end else begin
                req_addr = 16'({4'($urandom_range(0, 7)), 12'($urandom)});
                req_kind = 2'($urandom_range(0, 3));
                req_priv = 1'($urandom_range(0, 1));
                @(posedge clk); #1;
            end
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule